// File: doc/BRIEF.md
# Macroblock Pipeline Stage Sequencer

This controller paces a five-stage macroblock encoding pipeline. The stages run in a fixed order: full-pel motion search, half-pel refinement, forward transform with quantisation, inverse transform with quantisation, and variable-length coding. Each stage handles one macroblock per slot. A stage passes its result to the next stage through a double-buffered RAM. The stage datapaths are outside this block. The sequencer gives them a start pulse, a macroblock number and the half of each inter-stage buffer that is current.

A frame begins when `frame_start` is accepted. From then on, time is divided into slots of exactly `SLOT_CYCLES` clocks. A slot never waits for a stage. At the start of each slot, every occupied stage gets a one-cycle start pulse and all buffer selects flip. The macroblock tags then move one stage forward. The pipeline fills over the first four slots and drains over the last four, so a frame of N macroblocks takes N+4 slots. Any stage that has not raised its done flag by the last cycle of its slot sets a sticky error bit.

Top module: `mb_pipe_seq`

## Requirements
- R1: After reset, `stage_start`, `buf_sel`, `stage_mb`, `overrun_err`, `busy` and `frame_done` are all zero.
- R2: When `frame_start` is high, `busy` is low and `mb_count` is nonzero, the frame is accepted. One cycle later `busy` is high and `stage_start[0]` pulses with `stage_mb` field 0 equal to 0.
- R3: Within a frame, slot starts are exactly `SLOT_CYCLES` cycles apart. The schedule stays the same whatever the done flags are.
- R4: Number the slots of a frame from 0. Stage k (bit k of `stage_start`, where 0 is full-pel search and 4 is variable-length coding) pulses in slot s only if k <= s < k+N. So stage k first starts in slot k, and stage 0 gets no start after macroblock N-1 has entered. Start pulses last one cycle.
- R5: When stage k pulses in slot s, `stage_mb[k*MB_W +: MB_W]` equals s-k.
- R6: Bit j of `buf_sel` selects the half of the buffer between stage j and stage j+1. All four bits invert in each cycle in which start pulses are high, and they are unchanged in every other cycle.
- R7: `frame_done` pulses for one cycle, with `busy` falling in the same cycle. This happens (N+4)*`SLOT_CYCLES` cycles after the first start pulse of the frame.
- R8: Suppose stage k is occupied in a slot and its `stage_done[k]` is low in the last cycle of that slot. Then `overrun_err[k]` becomes 1 and stays 1 until the next accepted frame start, which clears it.
- R9: `frame_start` is ignored while `busy` is high, and it is ignored when `mb_count` is zero. Neither case changes the start schedule or `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Request to begin a frame |
| mb_count | input | MB_W | Macroblocks in the frame, sampled at acceptance |
| stage_done | input | 5 | Per-stage completion flags, sampled in the last slot cycle |
| stage_start | output | 5 | Per-stage one-cycle start pulses |
| buf_sel | output | 4 | Ping-pong half select for each inter-stage buffer |
| stage_mb | output | 5*MB_W | Macroblock number held by each stage |
| overrun_err | output | 5 | Sticky per-stage late-completion flags |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest cases to reach are the fill and drain edges. Only there do some stages sit empty, and a one-macroblock frame is the extreme case, with the same tag travelling alone through all five stages. The bench runs frames of 1, 3 and 7 macroblocks with a short slot length. At every slot boundary it compares the full start vector and every tag against a schedule built from the slot index. In one frame, a done flag is held low and a stray `frame_start` is injected mid-frame. This checks that the schedule does not move, that only that stage's error bit sets, and that the next frame clears it.

// File: rtl/mbseq_pkg.sv
package mbseq_pkg;
  localparam int NSTAGE = 5;
  localparam int NBUF   = NSTAGE - 1;
endpackage

// File: rtl/mbseq_slot_timer.sv
module mbseq_slot_timer #(
  parameter int SLOT_CYCLES = 1468
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic slot_end
);
  localparam int CW = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (restart) cnt <= '0;
    else if (run)     cnt <= cnt + 1'b1;
  end

  assign slot_end = run && (cnt == LAST);
endmodule

// File: rtl/mbseq_stage.sv
module mbseq_stage #(
  parameter int MB_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            advance,
  input  logic            check,
  input  logic            clear_err,
  input  logic            in_valid,
  input  logic [MB_W-1:0] in_mb,
  input  logic            done,
  output logic            valid,
  output logic [MB_W-1:0] mb,
  output logic            start,
  output logic            overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      mb      <= '0;
      start   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      start <= advance && in_valid;
      if (advance) begin
        valid <= in_valid;
        if (in_valid) mb <= in_mb;
      end
      if (clear_err)                    overrun <= 1'b0;
      else if (check && valid && !done) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/mb_pipe_seq.sv
module mb_pipe_seq
  import mbseq_pkg::*;
#(
  parameter int SLOT_CYCLES = 1468,
  parameter int MB_W        = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frame_start,
  input  logic [MB_W-1:0]        mb_count,
  input  logic [NSTAGE-1:0]      stage_done,
  output logic [NSTAGE-1:0]      stage_start,
  output logic [NBUF-1:0]        buf_sel,
  output logic [NSTAGE*MB_W-1:0] stage_mb,
  output logic [NSTAGE-1:0]      overrun_err,
  output logic                   busy,
  output logic                   frame_done
);
  logic              running;
  logic [MB_W-1:0]   n_mb;
  logic [MB_W-1:0]   next_mb;
  logic              accept, slot_end, more, advance, finish, feed_more;
  logic [NSTAGE-1:0] occ;
  logic [MB_W-1:0]   tag [NSTAGE];

  assign accept    = !running && frame_start && (mb_count != '0);
  assign feed_more = next_mb < n_mb;
  assign more      = feed_more || (|occ[NSTAGE-2:0]);
  assign advance   = accept || (slot_end && more);
  assign finish    = slot_end && !more;

  mbseq_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .restart(advance), .run(running), .slot_end(slot_end)
  );

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    logic            in_v;
    logic [MB_W-1:0] in_t;
    if (k == 0) begin : g_head
      assign in_v = accept || feed_more;
      assign in_t = accept ? '0 : next_mb;
    end else begin : g_body
      assign in_v = running && occ[k-1];
      assign in_t = tag[k-1];
    end
    mbseq_stage #(.MB_W(MB_W)) u_stage (
      .clk(clk), .rst(rst), .advance(advance), .check(slot_end),
      .clear_err(accept), .in_valid(in_v), .in_mb(in_t),
      .done(stage_done[k]), .valid(occ[k]), .mb(tag[k]),
      .start(stage_start[k]), .overrun(overrun_err[k])
    );
    assign stage_mb[k*MB_W +: MB_W] = tag[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      frame_done <= 1'b0;
      n_mb       <= '0;
      next_mb    <= '0;
      buf_sel    <= '0;
    end else begin
      frame_done <= finish;
      if (accept) begin
        running <= 1'b1;
        n_mb    <= mb_count;
        next_mb <= MB_W'(1);
      end else if (finish) begin
        running <= 1'b0;
      end else if (advance && feed_more) begin
        next_mb <= next_mb + 1'b1;
      end
      if (advance) buf_sel <= ~buf_sel;
    end
  end

  assign busy = running;
endmodule

// File: rtl/mb_pipe_seq_chk.sv
module mb_pipe_seq_chk #(
  parameter int SLOT_CYCLES = 1468,
  parameter int MB_W        = 11
) (
  input logic            clk,
  input logic            rst,
  input logic            frame_start,
  input logic [MB_W-1:0] mb_count,
  input logic [4:0]      stage_start,
  input logic [3:0]      buf_sel,
  input logic [4:0]      overrun_err,
  input logic            busy,
  input logic            frame_done
);
  logic [31:0] gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else begin
      if (|stage_start)          gap <= 32'd1;
      else if (gap != 32'hFFFF_FFFF) gap <= gap + 32'd1;
      if (|stage_start)          seen <= 1'b1;
      else if (frame_done)       seen <= 1'b0;
    end
  end

  a_r3_slot_spacing: assert property (@(posedge clk) disable iff (rst)
    ((|stage_start) && seen) |-> (gap == SLOT_CYCLES));

  a_r4_start_in_frame: assert property (@(posedge clk) disable iff (rst)
    (|stage_start) |-> busy);

  a_r6_sel_flip: assert property (@(posedge clk) disable iff (rst)
    (|stage_start) |-> (buf_sel == ~$past(buf_sel)));

  a_r6_sel_hold: assert property (@(posedge clk) disable iff (rst)
    !(|stage_start) |-> $stable(buf_sel));

  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !busy);

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    !(frame_start && !busy && (mb_count != '0)) |=>
      ((overrun_err & $past(overrun_err)) == $past(overrun_err)));
endmodule

bind mb_pipe_seq mb_pipe_seq_chk #(.SLOT_CYCLES(SLOT_CYCLES), .MB_W(MB_W)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .mb_count(mb_count),
  .stage_start(stage_start), .buf_sel(buf_sel), .overrun_err(overrun_err),
  .busy(busy), .frame_done(frame_done)
);

// File: tb/mb_pipe_seq_test.sv
module mb_pipe_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 20;
  localparam int MBW  = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           frame_start = 1'b0;
  logic [MBW-1:0] mb_count = '0;
  logic [4:0]     stage_done = 5'h1F;
  logic [4:0]     stage_start;
  logic [3:0]     buf_sel;
  logic [5*MBW-1:0] stage_mb;
  logic [4:0]     overrun_err;
  logic           busy, frame_done;

  int checks = 0;
  int fails  = 0;

  mb_pipe_seq #(.SLOT_CYCLES(SLOT), .MB_W(MBW)) uut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .mb_count(mb_count),
    .stage_done(stage_done), .stage_start(stage_start), .buf_sel(buf_sel),
    .stage_mb(stage_mb), .overrun_err(overrun_err), .busy(busy),
    .frame_done(frame_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input int n, input logic [4:0] mask, input bit poke);
    logic [3:0] b0;
    int total, stray;
    stage_done = mask;
    b0 = buf_sel;
    frame_start = 1'b1;
    mb_count = MBW'(n);
    @(negedge clk);
    frame_start = 1'b0;
    total = (n + 4) * SLOT;
    stray = 0;
    chk(busy == 1'b1, "R2 busy after accept", busy, 1);
    chk(overrun_err == 5'd0, "R8 cleared at accept", overrun_err, 0);
    for (int t = 0; t <= total; t++) begin
      if (t > 0) @(negedge clk);
      if (poke) frame_start = (t == SLOT + 3);
      if (t < total && (t % SLOT) == 0) begin
        int s;
        logic [4:0] es;
        logic [3:0] eb;
        s = t / SLOT;
        es = '0;
        for (int k = 0; k < 5; k++) if (k <= s && s < k + n) es[k] = 1'b1;
        chk(stage_start == es, "R4 start vector in slot", stage_start, es);
        for (int k = 0; k < 5; k++)
          if (es[k]) chk(int'(stage_mb[k*MBW +: MBW]) == s - k, "R5 stage tag",
                         stage_mb[k*MBW +: MBW], s - k);
        eb = ((s + 1) % 2 == 1) ? ~b0 : b0;
        chk(buf_sel == eb, "R6 buffer selects", buf_sel, eb);
      end else if (t < total) begin
        if (stage_start != 5'd0 || frame_done) stray++;
      end
    end
    frame_start = 1'b0;
    chk(stray == 0, "R3 no start between slot boundaries", stray, 0);
    chk(frame_done == 1'b1, "R7 frame_done at end", frame_done, 1);
    chk(busy == 1'b0, "R7 busy falls with frame_done", busy, 0);
    @(negedge clk);
    chk(frame_done == 1'b0, "R7 frame_done one cycle", frame_done, 0);
    chk(overrun_err == ~mask, "R8 overrun bits", overrun_err, ~mask);
    stage_done = 5'h1F;
  endtask

  task automatic t_reset;
    chk(stage_start == 0 && buf_sel == 0 && stage_mb == 0, "R1 reset outputs",
        {stage_start, buf_sel}, 0);
    chk(!busy && !frame_done && overrun_err == 0, "R1 reset status",
        {busy, frame_done, overrun_err}, 0);
  endtask

  task automatic t_zero_count;
    int seen;
    seen = 0;
    frame_start = 1'b1;
    mb_count = '0;
    @(negedge clk);
    frame_start = 1'b0;
    for (int i = 0; i < 2 * SLOT; i++) begin
      if (busy || stage_start != 0) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R9 zero count ignored", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_frame(3, 5'h1F, 1'b0);   // R2 R4 R5 R6 R7 basic
    run_frame(1, 5'h1F, 1'b0);   // R4 single macroblock fill/drain
    run_frame(7, 5'h1F, 1'b0);   // R5 longer frame
    run_frame(4, 5'h1B, 1'b1);   // R8 stage 2 late, R9 busy poke, R3 fixed slots
    run_frame(2, 5'h1F, 1'b0);   // R8 error cleared by next frame
    t_zero_count();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule